// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor

This block is a minimal processor with exactly one operation. Each instruction names two source registers and a destination register and carries a jump target. In every cycle the core subtracts the second source from the first and writes the difference to the destination. If the difference is negative, the program counter jumps to the target. Otherwise it moves on by one 4-byte word. Repeated subtraction and conditional jumps are enough to build loops and counters, so the block is a useful small programmable sequencer.

The fields sit at fixed positions in a wide instruction word, so the core has no opcode decoder. The program lives in an instruction array. Reset fills this array from a parameter image. Reset also sets the register file to a second parameter image (all zeros by default) and clears the program counter. A debug port reads any register at any time. A halt flag marks a jump to the current address, which is a one-instruction endless loop.

Top module: `subneg_cpu`

## Requirements
- R1: Every instruction writes the 32-bit wrapped difference src1 − src2 to its destination register at the clock edge that ends the instruction.
- R2: When bit 31 of the difference is 1, the program counter loads the instruction's target at that edge.
- R3: When bit 31 of the difference is 0, the program counter increases by 4 at that edge.
- R4: A difference of exactly zero counts as not negative, so the core does not jump.
- R5: Register 0 always reads zero, and the core discards any write to it.
- R6: The jump decision uses only bit 31, even when the subtraction overflows (0x80000000 − 1 gives 0x7FFFFFFF and does not jump).
- R7: The halt output is 1 exactly when the current instruction jumps to its own address. While halt is 1, the program counter holds its value.
- R8: While the active-low reset is low, the program counter is 0, every register holds its entry from the register image, and the instruction array reloads from the program image.
- R9: The instruction word is 47 bits: src1 address in [46:42], src2 address in [41:37], destination address in [36:32], and target in [31:0]. The core fetches the word at array index pc[5:2].
- R10: The debug port returns the current contents of the addressed register combinationally.
- R11: When the destination is also a source, the subtraction uses the register's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgAddr | input | 5 | Register selected for the debug read |
| dbgData | output | 32 | Contents of the selected register |
| pcOut | output | 32 | Current program counter |
| haltOut | output | 1 | Current instruction jumps to its own address |

## Verification
A single instruction does two things in the same cycle: it writes its result and it picks the next program counter, possibly raising halt. The directed program includes instructions that write a negative result while jumping, and a self-jump that keeps writing on every cycle while halted. After each edge the bench checks both the new program counter and the written register. A countdown loop decrements a register into itself, which puts a read and a write of the same register in one cycle. The bench checks each intermediate value to confirm the subtraction uses the pre-write value.

// File: rtl/subneg_pkg.sv
package subneg_pkg;

  // Amount the program counter advances on a non-jump.
  localparam int unsigned PcStep = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;        // commit result to destination register
    logic takeBranch;  // next pc comes from the target field
    logic halt;        // target equals the current pc while jumping
  } ctrl_strobes_t;

endpackage

// File: rtl/subneg_rom.sv
module subneg_rom #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned WORD_W  = 47,
  parameter int unsigned IDX_W   = 4,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdWord
);

  logic [WORD_W-1:0] mem [DEPTH];

  // The array takes the image on reset and is read-only afterwards.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < int'(DEPTH); k++) begin
        mem[k] <= IMAGE[k*WORD_W +: WORD_W];
      end
    end else begin
      for (int k = 0; k < int'(DEPTH); k++) begin
        mem[k] <= mem[k];
      end
    end
  end

  assign rdWord = mem[rdIdx];

endmodule

// File: rtl/subneg_datapath.sv
module subneg_datapath
  import subneg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5,
  parameter logic [(1<<REG_AW)*DATA_W-1:0] REG_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] srcAAddr,
  input  logic [REG_AW-1:0] srcBAddr,
  input  logic [REG_AW-1:0] dstAddr,
  input  ctrl_strobes_t     strobes,
  input  logic [REG_AW-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic              diffNeg
);

  localparam int unsigned NumRegs = 1 << REG_AW;

  logic [DATA_W-1:0] regRd [NumRegs];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] diff;

  for (genvar i = 0; i < int'(NumRegs); i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regRd[i] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= REG_IMAGE[i*DATA_W +: DATA_W];
        end else if (strobes.wrEn && dstAddr == REG_AW'(i)) begin
          q <= diff;
        end
      end
      assign regRd[i] = q;
    end
  end

  assign opA     = regRd[srcAAddr];
  assign opB     = regRd[srcBAddr];
  assign diff    = opA - opB;
  assign diffNeg = diff[DATA_W-1];
  assign dbgData = regRd[dbgAddr];

  AST_RESULT_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && dstAddr != '0) |=> regRd[$past(dstAddr)] == $past(diff)); // R1

  AST_ZERO_NO_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (diff == '0) |-> !strobes.takeBranch); // R4

  AST_HALT_NEEDS_NEG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.halt |-> strobes.takeBranch); // R7

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dbgAddr == '0) |-> dbgData == '0); // R5

endmodule

// File: rtl/subneg_control.sv
module subneg_control
  import subneg_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] target,
  input  logic            diffNeg,
  output logic [PC_W-1:0] pcQ,
  output ctrl_strobes_t   strobes
);

  logic [PC_W-1:0] nextPc;

  always_comb begin
    strobes.wrEn       = 1'b1;
    strobes.takeBranch = diffNeg;
    strobes.halt       = diffNeg && (target == pcQ);
    nextPc = diffNeg ? target : pcQ + PC_W'(PcStep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= nextPc;
  end

  AST_JUMP_LOADS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeBranch |=> pcQ == $past(target)); // R2

  AST_FALLTHROUGH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeBranch |=> pcQ == $past(pcQ) + PC_W'(PcStep)); // R3

  AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.halt |=> $stable(pcQ)); // R7

endmodule

// File: rtl/subneg_cpu.sv
module subneg_cpu
  import subneg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned ROM_DEPTH = 16,
  parameter logic [ROM_DEPTH*(3*REG_AW+DATA_W)-1:0] PROG_IMAGE = '0,
  parameter logic [(1<<REG_AW)*DATA_W-1:0]          REG_IMAGE  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic [DATA_W-1:0] pcOut,
  output logic              haltOut
);

  localparam int unsigned InstrW = 3*REG_AW + DATA_W;
  localparam int unsigned RomAw  = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic [InstrW-1:0] instr;
  logic [REG_AW-1:0] srcAAddr;
  logic [REG_AW-1:0] srcBAddr;
  logic [REG_AW-1:0] dstAddr;
  logic [DATA_W-1:0] target;
  logic [DATA_W-1:0] pcQ;
  logic [RomAw-1:0]  romIdx;
  logic              diffNeg;
  ctrl_strobes_t     strobes;

  // Fixed field positions: no decoding.
  assign srcAAddr = instr[InstrW-1 -: REG_AW];
  assign srcBAddr = instr[InstrW-1-REG_AW -: REG_AW];
  assign dstAddr  = instr[InstrW-1-2*REG_AW -: REG_AW];
  assign target   = instr[DATA_W-1:0];
  assign romIdx   = pcQ[RomAw+1:2];

  subneg_rom #(
    .DEPTH (ROM_DEPTH),
    .WORD_W(InstrW),
    .IDX_W (RomAw),
    .IMAGE (PROG_IMAGE)
  ) uRom (
    .clk   (clk),
    .rstN  (rstN),
    .rdIdx (romIdx),
    .rdWord(instr)
  );

  subneg_control #(
    .PC_W(DATA_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .target (target),
    .diffNeg(diffNeg),
    .pcQ    (pcQ),
    .strobes(strobes)
  );

  subneg_datapath #(
    .DATA_W   (DATA_W),
    .REG_AW   (REG_AW),
    .REG_IMAGE(REG_IMAGE)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .srcAAddr(srcAAddr),
    .srcBAddr(srcBAddr),
    .dstAddr (dstAddr),
    .strobes (strobes),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData),
    .diffNeg (diffNeg)
  );

  assign pcOut   = pcQ;
  assign haltOut = strobes.halt;

endmodule

// File: tb/subneg_cpu_test.sv
module subneg_cpu_test;

  localparam int CLK_PERIOD = 10;

  function automatic logic [46:0] mk(input int a, input int b, input int d,
                                     input logic [31:0] t);
    return {a[4:0], b[4:0], d[4:0], t};
  endfunction

  // Program (word address: effect)
  // 00 r7=r1-r2 (5-3)    -> 04      04 r8=r2-r1 (-2)   -> jump 10
  // 08/0C self-jump traps           10 r9=r3-r3 (0)     -> 14
  // 14 r0=r1-r2 discard  -> 18      18 r5=r5-r3 exit to 20 when negative
  // 1C r10=r0-r3 (-1) jump 18       20 r11=r6-r3 overflow -> 24
  // 24 r12=r0-r3 jump 24 (halt)
  localparam logic [16*47-1:0] PROG = {
    {6{47'd0}},
    mk(0, 3, 12, 32'h24), mk(6, 3, 11, 32'h08),
    mk(0, 3, 10, 32'h18), mk(5, 3, 5, 32'h20),
    mk(1, 2, 0, 32'h08),  mk(3, 3, 9, 32'h08),
    mk(0, 3, 0, 32'h0C),  mk(0, 3, 0, 32'h08),
    mk(2, 1, 8, 32'h10),  mk(1, 2, 7, 32'h40)};

  function automatic logic [1023:0] mkRegs();
    logic [1023:0] v = '0;
    v[1*32 +: 32] = 32'd5;
    v[2*32 +: 32] = 32'd3;
    v[3*32 +: 32] = 32'd1;
    v[5*32 +: 32] = 32'd7;
    v[6*32 +: 32] = 32'h8000_0000;
    return v;
  endfunction
  localparam logic [1023:0] REGS = mkRegs();

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;
  logic [31:0] pcOut;
  logic        haltOut;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  subneg_cpu #(.PROG_IMAGE(PROG), .REG_IMAGE(REGS)) uut (
    .clk(clk), .rstN(rstN), .dbgAddr(dbgAddr), .dbgData(dbgData),
    .pcOut(pcOut), .haltOut(haltOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input int a, output logic [31:0] v);
    dbgAddr = a[4:0];
    #1;
    v = dbgData;
  endtask

  task automatic checkReg(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(req, v, exp);
  endtask

  // One instruction edge, then sample pc and halt away from the edge.
  task automatic step(input string req, input logic [31:0] expPc);
    @(posedge clk);
    @(negedge clk);
    check(req, pcOut, expPc);
    check("R7 halt flag", {31'd0, haltOut}, {31'd0, expPc == 32'h24});
  endtask

  task automatic testReset();
    check("R8 pc at reset", pcOut, 32'h0);
    check("R8 halt at reset", {31'd0, haltOut}, 32'd0);
    checkReg("R8 r1 image", 1, 32'd5);
    checkReg("R8 r7 cleared", 7, 32'd0);
    checkReg("R10 r6 image via debug", 6, 32'h8000_0000);
  endtask

  task automatic testFallThrough();
    step("R3 no jump advances by 4", 32'h4);
    checkReg("R1 r7=5-3", 7, 32'd2);
  endtask

  task automatic testJump();
    step("R2 negative jumps to target", 32'h10);
    checkReg("R1 r8=3-5 wraps", 8, 32'hFFFF_FFFE);
  endtask

  task automatic testZero();
    step("R4 zero does not jump", 32'h14);
    checkReg("R4 r9 zero", 9, 32'd0);
  endtask

  task automatic testDiscard();
    step("R5 pc after r0 write", 32'h18);
    checkReg("R5 r0 stays zero", 0, 32'd0);
  endtask

  task automatic testLoop();
    step("R3 loop body", 32'h1C);
    checkReg("R11 r5 uses old value", 5, 32'd6);
    step("R2 loop back", 32'h18);
    for (int k = 0; k < 6; k++) begin
      step("R3 loop body", 32'h1C);
      step("R2 loop back", 32'h18);
    end
    checkReg("R11 r5 reached zero", 5, 32'd0);
    step("R2 loop exit on negative", 32'h20);
    checkReg("R11 r5 final", 5, 32'hFFFF_FFFF);
    checkReg("R5 r0 read as zero source", 10, 32'hFFFF_FFFF);
  endtask

  task automatic testOverflow();
    step("R6 overflow result not negative", 32'h24);
    checkReg("R6 r11 wrapped", 11, 32'h7FFF_FFFF);
  endtask

  task automatic testHalt();
    for (int k = 0; k < 3; k++) begin
      step("R7 halted pc holds", 32'h24);
    end
    checkReg("R1 halt instruction still writes", 12, 32'hFFFF_FFFF);
  endtask

  task automatic testMidReset();
    rstN = 1'b0;
    #1;
    check("R8 pc cleared", pcOut, 32'h0);
    checkReg("R8 r5 restored", 5, 32'd7);
    checkReg("R8 r12 restored", 12, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    step("R9 refetch word 0 after reset", 32'h4);
    checkReg("R9 src fields decoded", 7, 32'd2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFallThrough();
    testJump();
    testZero();
    testDiscard();
    testLoop();
    testOverflow();
    testHalt();
    testMidReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule